// File: doc/BRIEF.md
# Multi-Mode Position Counter

This block keeps a 32-bit signed-agnostic position value whose count source is picked by a two-bit mode input. Two phase pins, A and B, are shared by three of the modes: they can be decoded as a quadrature pair, used as a count pulse with a separate direction level, or used as a count pulse with an optional gate level. The fourth mode ignores the pins and advances the counter from a timebase derived by dividing the system clock by a programmable amount.

Both phase pins pass through a two-flop synchroniser before any edge is detected, so pin changes reach the counter a fixed number of cycles later. Software may overwrite the counter at any time through a write strobe and data word, and reads it back on the count output. Counting wraps around freely in both directions.

Top module: `posmode_counter`

## Requirements
- R1: While reset is asserted and on the first cycle after its release, the count output is zero.
- R2: When the write strobe is high at a rising clock edge, the count takes the write data on that edge, even if a count event occurs in the same cycle.
- R3: In quadrature mode (mode value 0), with the phase state ordered 00, 10, 11, 01 for {A,B}, a single step forward in that order adds one to the count and a single step backward subtracts one, so each edge of either pin counts once.
- R4: In quadrature mode, a change in which A and B both toggle at once leaves the count unchanged.
- R5: In external direction mode (mode value 1), each rising edge of A adds one if B is high and subtracts one if B is low; falling edges of A do not change the count.
- R6: In gated mode (mode value 2), each rising edge of A adds one when the gate enable is 0, whatever B is; when the gate enable is 1 it adds one only if B is high.
- R7: In timer mode (mode value 3), the count rises by one every divider value + 1 cycles; after entering the mode, the first increment happens on the (divider value + 2)-th rising edge, since the prescaler restarts on the mode change.
- R8: The count wraps modulo 2^32: one step up from all ones gives zero and one step down from zero gives all ones.
- R9: A phase pin change applied between clock edges is reflected in the count on the third rising edge after it and not earlier.
- R10: Without a write the count changes by at most one per cycle, and in gated and timer modes it never decreases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Count source: 0 quadrature, 1 external with direction, 2 external gated, 3 internal timer |
| gate_en | input | 1 | In gated mode, lets pin B gate the count pulses |
| div_val | input | 16 | Timer prescale value; period is div_val + 1 cycles |
| phase_a | input | 1 | Phase A, or count pulse in the external modes |
| phase_b | input | 1 | Phase B, direction level, or gate level depending on mode |
| wr_en | input | 1 | Load strobe for the counter |
| wr_data | input | 32 | Value loaded when wr_en is high |
| count | output | 32 | Current counter value |

## Verification
The hardest situations to reach are the quadrature transitions that never occur on a healthy encoder, both pins toggling at once and stepping backward through the Gram of states, and the exact cycle at which the timer first fires after a mode switch. The bench drives every ordered pair of the four phase states, so all sixteen transitions including the illegal diagonals are applied from every starting state, and it checks the count on every cycle after entering timer mode for several divider values. Write priority is reached by loading the counter while the timer ticks every cycle, so a load and a count event always share an edge.

// File: rtl/posctr_pkg.sv
// Package: shared types for the multi-mode position counter.
// Assumes the mode field is two bits and its encoding is fixed below.
package posctr_pkg;

    typedef enum logic [1:0] {
        SRC_QUAD     = 2'd0,
        SRC_EXT_DIR  = 2'd1,
        SRC_EXT_GATE = 2'd2,
        SRC_TIMER    = 2'd3
    } src_mode_t;

    // Index positions of the two phase pins in the packed phase vector.
    localparam int PH_A = 1;
    localparam int PH_B = 0;

endpackage

// File: rtl/posctr_sync.sv
// Module: posctr_sync
// Brings W asynchronous pins into the clock domain through STAGES flops and
// keeps one extra delayed copy so callers can detect edges.
// Assumes STAGES >= 2 and that pins stay stable for at least one cycle.
module posctr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] stg [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= pin_i;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            // Each further stage re-samples the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    // Delayed copy of the synchronised value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_o <= '0;
        else        prev_o <= stg[STAGES-1];
    end

    assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/posctr_quad.sv
// Module: posctr_quad
// Combinational quadrature decoder. Compares the present and previous
// synchronised {A,B} states and reports one step with its direction when
// exactly one pin changed. A double change yields no step.
// Assumes the inputs come from the same synchroniser so they are aligned.
module posctr_quad (
    input  logic [1:0] cur_i,
    input  logic [1:0] prv_i,
    output logic       step_o,
    output logic       up_o
);
    import posctr_pkg::*;

    logic a_chg;
    logic b_chg;

    // Decode single-pin changes; forward when new B equals old A.
    always_comb begin
        a_chg  = cur_i[PH_A] ^ prv_i[PH_A];
        b_chg  = cur_i[PH_B] ^ prv_i[PH_B];
        step_o = a_chg ^ b_chg;
        up_o   = (cur_i[PH_B] == prv_i[PH_A]);
    end

endmodule

// File: rtl/posctr_prescale.sv
// Module: posctr_prescale
// Timebase divider: emits a one-cycle tick every div_i + 1 cycles while
// run_i is high. restart_i clears the prescale count and suppresses the
// tick of that cycle. Assumes div_i may change at any time; a count that
// has overtaken a lowered divider ticks at once.
module posctr_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] pre_q;
    logic             at_end;

    // Terminal detection of the prescale count.
    always_comb begin
        at_end = (pre_q >= div_i);
        tick_o = run_i && !restart_i && at_end;
    end

    // Prescale counter: hold at zero when idle or restarting.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pre_q <= '0;
        else if (!run_i || restart_i) pre_q <= '0;
        else if (at_end)              pre_q <= '0;
        else                          pre_q <= pre_q + 1'b1;
    end

endmodule

// File: rtl/posctr_accum.sv
// Module: posctr_accum
// Holds the position value. A write has priority over a step; steps add or
// subtract one with natural wrap at the register width.
module posctr_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             step_i,
    input  logic             up_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] nxt;

    // Choose next value: load, increment, decrement or hold.
    always_comb begin
        if (wr_i)        nxt = wdata_i;
        else if (!step_i) nxt = cnt_o;
        else if (up_i)   nxt = cnt_o + 1'b1;
        else             nxt = cnt_o - 1'b1;
    end

    // Position register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= nxt;
    end

endmodule

// File: rtl/posmode_counter.sv
// Module: posmode_counter (top)
// Multi-source position counter. Synchronises the phase pins, decodes them
// according to the selected mode or uses the divided timebase, and feeds a
// loadable wrap-around counter. Assumes the mode input is quasi-static and
// that pin pulses last at least two clock cycles per level.
module posmode_counter #(
    parameter int CNT_W       = 32,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             gate_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count
);
    import posctr_pkg::*;

    localparam int NPH = 2;

    src_mode_t        mode_e;
    src_mode_t        mode_q;
    logic [NPH-1:0]   ph_raw;
    logic [NPH-1:0]   ph_s;
    logic [NPH-1:0]   ph_p;
    logic             q_step;
    logic             q_up;
    logic             tick;
    logic             mode_chg;
    logic             a_rise;
    logic             ev_step;
    logic             ev_up;

    assign mode_e = src_mode_t'(mode);

    // Pack the pins in the package-defined order.
    always_comb begin
        ph_raw       = '0;
        ph_raw[PH_A] = phase_a;
        ph_raw[PH_B] = phase_b;
    end

    posctr_sync #(
        .W      (NPH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ph_raw),
        .sync_o (ph_s),
        .prev_o (ph_p)
    );

    posctr_quad u_quad (
        .cur_i  (ph_s),
        .prv_i  (ph_p),
        .step_o (q_step),
        .up_o   (q_up)
    );

    // Remember the last mode so a change can restart the prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= SRC_QUAD;
        else        mode_q <= mode_e;
    end

    assign mode_chg = (mode_e != mode_q);

    posctr_prescale #(
        .DIV_W (DIV_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (mode_e == SRC_TIMER),
        .restart_i (mode_chg),
        .div_i     (div_val),
        .tick_o    (tick)
    );

    assign a_rise = ph_s[PH_A] & ~ph_p[PH_A];

    // Route the count event and direction of the selected source.
    always_comb begin
        ev_step = 1'b0;
        ev_up   = 1'b1;
        unique case (mode_e)
            SRC_QUAD: begin
                ev_step = q_step;
                ev_up   = q_up;
            end
            SRC_EXT_DIR: begin
                ev_step = a_rise;
                ev_up   = ph_s[PH_B];
            end
            SRC_EXT_GATE: begin
                ev_step = a_rise && (!gate_en || ph_s[PH_B]);
                ev_up   = 1'b1;
            end
            SRC_TIMER: begin
                ev_step = tick;
                ev_up   = 1'b1;
            end
            default: begin
                ev_step = 1'b0;
                ev_up   = 1'b1;
            end
        endcase
    end

    posctr_accum #(
        .CNT_W (CNT_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_en),
        .wdata_i (wr_data),
        .step_i  (ev_step),
        .up_i    (ev_up),
        .cnt_o   (count)
    );

endmodule

// File: rtl/posctr_checker.sv
// Module: posctr_checker
// Temporal checks on the ports of posmode_counter, bound to every instance.
module posctr_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] count
);

    // A load always wins over any count event of the same edge.
    assert_wr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));

    // Without a load, the value moves by at most one.
    assert_step_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count == $past(count) ||
                    count == $past(count) + 1'b1 ||
                    count == $past(count) - 1'b1));

    // Gated and timer modes count up only.
    assert_up_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && mode[1]) |=> (count == $past(count) ||
                                 count == $past(count) + 1'b1));

    // Entering timer mode never ticks on the entry edge.
    assert_entry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && mode == 2'd3 && $past(mode) != 2'd3) |=> $stable(count));

endmodule

bind posmode_counter posctr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .count   (count)
);

// File: tb/posmode_counter_bench.sv
module posmode_counter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 32;
    localparam int DIV_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       mode;
    logic             gate_en;
    logic [DIV_W-1:0] div_val;
    logic             phase_a;
    logic             phase_b;
    logic             wr_en;
    logic [CNT_W-1:0] wr_data;
    logic [CNT_W-1:0] count;

    int n_chk  = 0;
    int n_fail = 0;
    logic [CNT_W-1:0] exp_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    posmode_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_posmode_counter (
        .clk(clk), .rst_n(rst_n), .mode(mode), .gate_en(gate_en),
        .div_val(div_val), .phase_a(phase_a), .phase_b(phase_b),
        .wr_en(wr_en), .wr_data(wr_data), .count(count)
    );

    task automatic check(input string req, input logic [CNT_W-1:0] exp);
        n_chk++;
        if (count !== exp) begin
            n_fail++;
            $display("FAIL %s: count=%h expected=%h", req, count, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Apply pins at a negedge and let them settle through sync and edge detect.
    task automatic pins(input logic a, input logic b);
        phase_a = a;
        phase_b = b;
        cycles(4);
    endtask

    task automatic load(input logic [CNT_W-1:0] v);
        wr_en   = 1'b1;
        wr_data = v;
        cycles(1);
        wr_en   = 1'b0;
        exp_cnt = v;
    endtask

    // Gray position of {A,B}: 00,10,11,01.
    function automatic int gpos(input logic [1:0] s);
        case (s)
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: count=%h expected=done", count);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = 2'd0; gate_en = 1'b0; div_val = '0;
        phase_a = 1'b0; phase_b = 1'b0; wr_en = 1'b0; wr_data = '0;
        exp_cnt = '0;
        cycles(3);
        check("R1 in reset", '0);
        rst_n = 1'b1;
        cycles(1);
        check("R1 after release", '0);

        // Quadrature: every ordered pair of states, legal and illegal.
        mode = 2'd0;
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic [1:0] from;
                logic [1:0] to;
                int d;
                from = 2'(i);
                to   = 2'(j);
                d = (gpos({phase_a, phase_b}) - 0);
                d = (gpos(from) - d + 4) % 4;
                if (d == 1) exp_cnt = exp_cnt + 1;
                if (d == 3) exp_cnt = exp_cnt - 1;
                pins(from[1], from[0]);
                check(d == 2 ? "R4 walk" : "R3 walk", exp_cnt);
                d = (gpos(to) - gpos(from) + 4) % 4;
                if (d == 1) exp_cnt = exp_cnt + 1;
                if (d == 3) exp_cnt = exp_cnt - 1;
                pins(to[1], to[0]);
                check(d == 2 ? "R4 double toggle" : "R3 single step", exp_cnt);
            end
        end

        // Wrap in both directions using a quadrature step from 00.
        pins(1'b0, 1'b0);
        load('1);
        pins(1'b1, 1'b0);
        check("R8 wrap up", '0);
        pins(1'b0, 1'b0);
        check("R8 wrap down", '1);

        // External direction mode, including the latency of a pin change.
        mode = 2'd1;
        load(32'h100);
        pins(1'b0, 1'b1);
        phase_a = 1'b1;
        cycles(2);
        check("R9 no change before third edge", exp_cnt);
        cycles(1);
        exp_cnt = exp_cnt + 1;
        check("R9 change on third edge", exp_cnt);
        for (int k = 0; k < 6; k++) begin
            logic b;
            b = logic'(k % 3 != 0);
            pins(1'b0, b);
            check("R5 falling A ignored", exp_cnt);
            pins(1'b1, b);
            exp_cnt = b ? exp_cnt + 1 : exp_cnt - 1;
            check("R5 rising A with direction", exp_cnt);
        end

        // Gated mode over both gate settings and both B levels.
        mode = 2'd2;
        pins(1'b0, 1'b0);
        load(32'h20);
        for (int g = 0; g < 2; g++) begin
            for (int b = 0; b < 2; b++) begin
                gate_en = logic'(g);
                pins(1'b0, logic'(b));
                pins(1'b1, logic'(b));
                if (g == 0 || b == 1) exp_cnt = exp_cnt + 1;
                check("R6 gated pulse", exp_cnt);
            end
        end
        gate_en = 1'b0;

        // Timer mode: sample every cycle after entry for several dividers.
        for (int d = 0; d < 5; d++) begin
            mode = 2'd0;
            pins(1'b0, 1'b0);
            load('0);
            mode    = 2'd3;
            div_val = DIV_W'(d);
            for (int k = 1; k <= 12; k++) begin
                cycles(1);
                check("R7 timer cadence", CNT_W'((k - 1) / (d + 1)));
            end
        end

        // Write versus a same-cycle tick (divider 0 ticks every cycle).
        div_val = '0;
        wr_en   = 1'b1;
        wr_data = 32'hDEAD_0000;
        cycles(1);
        wr_en = 1'b0;
        check("R2 write wins", 32'hDEAD_0000);
        cycles(1);
        check("R10 single step after load", 32'hDEAD_0001);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule